// File: doc/BRIEF.md
# Accumulator Readout and Shift-Add Stage

This block is the output stage of an eight-cell multiply-accumulate filter. Each filter cell offers a 26-bit accumulator value on an input port. A 3-bit address chooses one of these cells, and the stage drives a 26-bit result bus. The bus source is either the addressed cell or an internal output buffer. The buffer supports multi-pass extended-precision sums. On every clock it takes the addressed cell value. When the shift-add control is high, it also adds its own previous contents, arithmetically shifted right by eight places.

The choice of source has one clock of history. The addressed cell reaches the bus only when the shift-add control was low at the present clock edge and also at the edge before it. At any other time the buffer is shown. A held address freezes the cell-side value, so a slow consumer sees a stable word. The bus is split into a 16-bit low lane and a 10-bit high lane. Each lane has its own active-low enable. Tri-state drive is modelled as zeroed bits plus a per-lane valid flag.

Top module: `accout_stage`

## Requirements
- R1: The cell-side value is `cell_acc[adr]`, sampled at the rising clock edge, where `cell_acc[i]` occupies bits `i*26+25` down to `i*26` of the port.
- R2: After an edge, `sum` shows the cell-side value if `shadd` was 0 at that edge and at the edge before it; otherwise it shows the output buffer.
- R3: While `adr` holds the same value across successive edges, the cell-side value stays at what was captured on the first edge of that address, even if that cell's input changes.
- R4: At an edge where `shadd` is 0, the buffer loads the addressed cell value unchanged.
- R5: At an edge where `shadd` is 1, the buffer loads the addressed cell value plus the old buffer shifted right by 8, with bits 25..18 of the shifted term copied from old bit 25, wrapping modulo 2^26.
- R6: `sum[15:0]` carries the source bits when `lo_en_n` is 0 and reads 0 when it is 1, with no clock delay.
- R7: `sum[25:16]` carries the source bits when `hi_en_n` is 0 and reads 0 when it is 1, with no clock delay.
- R8: `lo_valid` equals the inverse of `lo_en_n`, and `hi_valid` equals the inverse of `hi_en_n`, combinationally.
- R9: A synchronous high `rst` clears the registered address, the shift-add history and the buffer. The next edge with `shadd` 0 after reset therefore selects the cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cell_acc | input | 208 | Eight packed 26-bit cell accumulator values |
| adr | input | 3 | Cell address |
| shadd | input | 1 | Shift-add control, also sets source history |
| lo_en_n | input | 1 | Active-low enable for bits 15..0 |
| hi_en_n | input | 1 | Active-low enable for bits 25..16 |
| sum | output | 26 | Result bus, with disabled lanes reading 0 |
| lo_valid | output | 1 | Low lane driven |
| hi_valid | output | 1 | High lane driven |

## Verification
The address, source history, hold register and buffer all update at the same rising edge. Their effect on `sum` is therefore due one edge after the inputs are presented, and the bench samples one nanosecond after that edge. The lane enables and valid flags are combinational. The bench changes the enables only after a sample and checks them at the next sampling point, with no edge counted. A reference model in the bench steps once per edge from the same presented inputs. Each expected value is taken from that model right after its update.

// File: rtl/accout_pkg.sv
package accout_pkg;

    localparam int DEF_NCELL = 8;
    localparam int DEF_ACC_W = 26;
    localparam int DEF_SHIFT = 8;
    localparam int DEF_LO_W  = 16;

    typedef enum logic {
        SRC_CELL = 1'b0,
        SRC_BUF  = 1'b1
    } src_e;

    typedef struct packed {
        logic lo;
        logic hi;
    } lane_en_t;

endpackage

// File: rtl/accout_cell_hold.sv
module accout_cell_hold #(
    parameter int NCELL = accout_pkg::DEF_NCELL,
    parameter int ACC_W = accout_pkg::DEF_ACC_W,
    localparam int ADR_W = $clog2(NCELL)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NCELL-1:0][ACC_W-1:0] cell_acc,
    input  logic [ADR_W-1:0]            adr,
    output logic [ACC_W-1:0]            cell_now,
    output logic [ACC_W-1:0]            held_q,
    output logic [ADR_W-1:0]            adr_q,
    output logic                        hold_vld
);

    logic new_addr;

    assign cell_now = cell_acc[adr];
    assign new_addr = !hold_vld || (adr != adr_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            adr_q    <= '0;
            hold_vld <= 1'b0;
            held_q   <= '0;
        end else begin
            adr_q    <= adr;
            hold_vld <= 1'b1;
            if (new_addr) begin
                held_q <= cell_now;
            end
        end
    end

endmodule

// File: rtl/accout_shift_buf.sv
module accout_shift_buf #(
    parameter int ACC_W = accout_pkg::DEF_ACC_W,
    parameter int SHIFT = accout_pkg::DEF_SHIFT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             shadd,
    input  logic [ACC_W-1:0] cell_now,
    output logic [ACC_W-1:0] buf_q
);

    logic [ACC_W-1:0] fb_term;

    always_comb begin
        if (shadd) begin
            fb_term = {{SHIFT{buf_q[ACC_W-1]}}, buf_q[ACC_W-1:SHIFT]};
        end else begin
            fb_term = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_q <= '0;
        end else begin
            buf_q <= cell_now + fb_term;
        end
    end

endmodule

// File: rtl/accout_lane_gate.sv
module accout_lane_gate #(
    parameter int ACC_W = accout_pkg::DEF_ACC_W,
    parameter int LO_W  = accout_pkg::DEF_LO_W,
    localparam int HI_W = ACC_W - LO_W
) (
    input  logic [ACC_W-1:0]      src_val,
    input  accout_pkg::lane_en_t  lane_on,
    output logic [ACC_W-1:0]      sum
);

    localparam int NLANE = 2;
    localparam int LANE_LO [NLANE] = '{0, LO_W};
    localparam int LANE_W  [NLANE] = '{LO_W, HI_W};

    logic [NLANE-1:0] on_vec;
    assign on_vec = {lane_on.hi, lane_on.lo};

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        assign sum[LANE_LO[g] +: LANE_W[g]] =
            on_vec[g] ? src_val[LANE_LO[g] +: LANE_W[g]] : '0;
    end

endmodule

// File: rtl/accout_stage.sv
module accout_stage #(
    parameter int NCELL = accout_pkg::DEF_NCELL,
    parameter int ACC_W = accout_pkg::DEF_ACC_W,
    parameter int SHIFT = accout_pkg::DEF_SHIFT,
    parameter int LO_W  = accout_pkg::DEF_LO_W,
    localparam int ADR_W = $clog2(NCELL)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NCELL-1:0][ACC_W-1:0] cell_acc,
    input  logic [ADR_W-1:0]            adr,
    input  logic                        shadd,
    input  logic                        lo_en_n,
    input  logic                        hi_en_n,
    output logic [ACC_W-1:0]            sum,
    output logic                        lo_valid,
    output logic                        hi_valid
);

    import accout_pkg::*;

    logic [ACC_W-1:0] cell_now;
    logic [ACC_W-1:0] held_q;
    logic [ADR_W-1:0] adr_q;
    logic             hold_vld;
    logic [ACC_W-1:0] buf_q;
    logic             shadd_q;
    logic             shadd_h;
    src_e             src_sel;
    logic [ACC_W-1:0] src_val;
    lane_en_t         lane_on;

    accout_cell_hold #(.NCELL(NCELL), .ACC_W(ACC_W)) u_hold (
        .clk      (clk),
        .rst      (rst),
        .cell_acc (cell_acc),
        .adr      (adr),
        .cell_now (cell_now),
        .held_q   (held_q),
        .adr_q    (adr_q),
        .hold_vld (hold_vld)
    );

    accout_shift_buf #(.ACC_W(ACC_W), .SHIFT(SHIFT)) u_buf (
        .clk      (clk),
        .rst      (rst),
        .shadd    (shadd),
        .cell_now (cell_now),
        .buf_q    (buf_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            shadd_q <= 1'b0;
            shadd_h <= 1'b0;
        end else begin
            shadd_q <= shadd;
            shadd_h <= shadd_q;
        end
    end

    assign src_sel = (shadd_q || shadd_h) ? SRC_BUF : SRC_CELL;
    assign src_val = (src_sel == SRC_CELL) ? held_q : buf_q;

    assign lane_on.lo = ~lo_en_n;
    assign lane_on.hi = ~hi_en_n;
    assign lo_valid   = lane_on.lo;
    assign hi_valid   = lane_on.hi;

    accout_lane_gate #(.ACC_W(ACC_W), .LO_W(LO_W)) u_gate (
        .src_val (src_val),
        .lane_on (lane_on),
        .sum     (sum)
    );

endmodule

// File: rtl/accout_stage_chk.sv
module accout_stage_chk #(
    parameter int NCELL = accout_pkg::DEF_NCELL,
    parameter int ACC_W = accout_pkg::DEF_ACC_W,
    parameter int SHIFT = accout_pkg::DEF_SHIFT,
    parameter int LO_W  = accout_pkg::DEF_LO_W,
    localparam int ADR_W = $clog2(NCELL)
) (
    input logic                        clk,
    input logic                        rst,
    input logic [NCELL-1:0][ACC_W-1:0] cell_acc,
    input logic [ADR_W-1:0]            adr,
    input logic                        shadd,
    input logic                        lo_en_n,
    input logic                        hi_en_n,
    input logic [ACC_W-1:0]            sum,
    input logic                        lo_valid,
    input logic                        hi_valid,
    input logic [ACC_W-1:0]            buf_q,
    input logic [ACC_W-1:0]            held_q,
    input logic [ADR_W-1:0]            adr_q,
    input logic                        hold_vld
);

    // R3
    addr_hold_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(hold_vld) && adr_q == $past(adr_q)) |-> $stable(held_q));

    // R4
    buf_plain_load_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(shadd)) |-> buf_q == $past(cell_acc[adr]));

    // R2
    buf_shown_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(shadd) && !lo_en_n && !hi_en_n) |-> sum == buf_q);

    // R6
    lo_lane_off_chk: assert property (@(posedge clk) disable iff (rst)
        lo_en_n |-> sum[LO_W-1:0] == '0);

    // R7
    hi_lane_off_chk: assert property (@(posedge clk) disable iff (rst)
        hi_en_n |-> sum[ACC_W-1:LO_W] == '0);

    // R8
    valid_flags_chk: assert property (@(posedge clk) disable iff (rst)
        (lo_valid != lo_en_n) && (hi_valid != hi_en_n));

    // R9
    reset_clear_chk: assert property (@(posedge clk)
        $past(rst) |-> (buf_q == '0 && !hold_vld));

endmodule

bind accout_stage accout_stage_chk #(
    .NCELL(NCELL), .ACC_W(ACC_W), .SHIFT(SHIFT), .LO_W(LO_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cell_acc (cell_acc),
    .adr      (adr),
    .shadd    (shadd),
    .lo_en_n  (lo_en_n),
    .hi_en_n  (hi_en_n),
    .sum      (sum),
    .lo_valid (lo_valid),
    .hi_valid (hi_valid),
    .buf_q    (buf_q),
    .held_q   (held_q),
    .adr_q    (adr_q),
    .hold_vld (hold_vld)
);

// File: tb/accout_stage_test.sv
module accout_stage_test;

    localparam int NCELL = 8;
    localparam int ACC_W = 26;
    localparam int ADR_W = 3;

    logic                        clk = 1'b0;
    logic                        rst = 1'b1;
    logic [NCELL-1:0][ACC_W-1:0] cell_acc = '0;
    logic [ADR_W-1:0]            adr = '0;
    logic                        shadd = 1'b0;
    logic                        lo_en_n = 1'b0;
    logic                        hi_en_n = 1'b0;
    logic [ACC_W-1:0]            sum;
    logic                        lo_valid;
    logic                        hi_valid;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // bench reference state
    logic [ACC_W-1:0] m_hold, m_buf;
    logic [ADR_W-1:0] m_adrq;
    logic             m_vld, m_shq, m_shh;

    always #2.5 clk = ~clk;

    accout_stage uut (
        .clk(clk), .rst(rst), .cell_acc(cell_acc), .adr(adr), .shadd(shadd),
        .lo_en_n(lo_en_n), .hi_en_n(hi_en_n), .sum(sum),
        .lo_valid(lo_valid), .hi_valid(hi_valid)
    );

    function automatic logic [ACC_W-1:0] asr8(input logic [ACC_W-1:0] v);
        return {{8{v[ACC_W-1]}}, v[ACC_W-1:8]};
    endfunction

    function automatic logic [ACC_W-1:0] expect_sum();
        logic [ACC_W-1:0] s;
        s = (!m_shq && !m_shh) ? m_hold : m_buf;
        if (lo_en_n) s[15:0] = '0;
        if (hi_en_n) s[25:16] = '0;
        return s;
    endfunction

    task automatic check(input string req, input logic [ACC_W-1:0] act,
                         input logic [ACC_W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_out(input string req);
        check(req, sum, expect_sum());
        check("R8", {24'd0, hi_valid, lo_valid}, {24'd0, ~hi_en_n, ~lo_en_n});
    endtask

    task automatic model_reset();
        m_hold = '0; m_buf = '0; m_adrq = '0;
        m_vld = 1'b0; m_shq = 1'b0; m_shh = 1'b0;
    endtask

    // one edge: inputs already presented; update model, then sample
    task automatic step(input string req);
        logic [ACC_W-1:0] c;
        @(posedge clk);
        if (rst) begin
            model_reset();
        end else begin
            c = cell_acc[adr];
            if (!m_vld || adr != m_adrq) m_hold = c;
            m_adrq = adr;
            m_vld  = 1'b1;
            m_buf  = c + (shadd ? asr8(m_buf) : '0);
            m_shh  = m_shq;
            m_shq  = shadd;
        end
        #1;
        check_out(req);
    endtask

    task automatic fill_cells(input int seed);
        for (int i = 0; i < NCELL; i++)
            cell_acc[i] = ACC_W'((seed * 32'h9E3779B1) ^ (i * 32'h01234567) ^ (i << 21));
    endtask

    initial begin
        model_reset();
        fill_cells(1);
        // R9: reset state
        step("R9");
        step("R9");
        rst = 1'b0;

        // R1 R2: every address, control low
        for (int a = 0; a < NCELL; a++) begin
            adr = ADR_W'(a);
            step("R1 R2");
        end

        // R3: held address with changing cell input
        adr = 3'd5;
        step("R3");
        for (int k = 0; k < 5; k++) begin
            cell_acc[5] = cell_acc[5] + 26'h0012345;
            step("R3");
        end
        adr = 3'd6;
        step("R3");
        adr = 3'd5;
        step("R3 R1");

        // R2 R4 R5: all 4-bit shift-add patterns, address walking
        for (int p = 0; p < 16; p++) begin
            fill_cells(p + 7);
            for (int b = 0; b < 4; b++) begin
                shadd = p[b];
                adr   = ADR_W'(p + b);
                step("R2 R4 R5");
            end
        end

        // R5: long extended-precision run with negative values
        for (int k = 0; k < 12; k++) begin
            cell_acc[2] = (k % 2 == 0) ? 26'h3FF0000 : 26'h2000001;
            cell_acc[7] = 26'h1FFFFFF - ACC_W'(k);
            adr   = (k % 2 == 0) ? 3'd2 : 3'd7;
            shadd = 1'b1;
            step("R5");
        end
        shadd = 1'b0;
        step("R4");
        step("R2");

        // R6 R7 R8: lane combinations, combinational
        for (int l = 0; l < 4; l++) begin
            lo_en_n = l[0];
            hi_en_n = l[1];
            #1;
            check_out("R6 R7");
            shadd = l[1];
            adr   = ADR_W'(l);
            step("R6 R7");
        end
        lo_en_n = 1'b0;
        hi_en_n = 1'b0;

        // R9: mid-run reset then cell shown at first low control
        shadd = 1'b1;
        step("R5");
        rst = 1'b1;
        step("R9");
        rst = 1'b0;
        shadd = 1'b0;
        adr = 3'd4;
        step("R9");
        check("R9", sum, cell_acc[4]);
        step("R9");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end

endmodule